// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. It takes the memory from the moment reset is released to the point where normal traffic may start. While it runs, it owns the clock-enable, data-mask, command and address pins. The sequence has a fixed order. First it holds a long quiet period with only no-operation commands on the bus. Then it closes every bank with a single precharge-all. Next it issues a burst of auto-refresh commands, each spaced by the row-cycle time. Finally it writes the mode register and raises a ready flag once the mode-set recovery time has passed.

Every wait is a cycle-count parameter, and so is the number of refreshes. An elaboration check rejects any refresh count below eight. The mode word carries burst length, burst ordering and CAS latency, which the block takes from three configuration inputs. The controller is expected to hold these inputs steady during initialization. Every command is one cycle long, and every cycle without a command carries a no-operation. After ready, the block keeps driving no-operation until reset, which lets the traffic controller take over the bus. Asserting reset at any point starts the whole sequence again.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is low, and on every cycle afterwards, `sd_cke` and `sd_dqm` are 1. During reset the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (no-operation), `sd_addr` is zero and `init_done` is 0.
- R2: Number the cycles from the release of reset (index 0, before the first rising edge). The first command other than no-operation appears at index `WAIT_STABLE_CYC`.
- R3: That first command is a precharge-all: the command pins read 4'b0010 and `sd_addr` has only bit 10 set.
- R4: The first auto-refresh comes exactly `T_RP_CYC` cycles after the precharge.
- R5: Exactly `REFRESH_COUNT` auto-refresh commands are issued, each with pins 4'b0001 and `sd_addr` zero. Consecutive refreshes are exactly `T_RC_CYC` cycles apart.
- R6: A mode register set (pins 4'b0000) comes `T_RC_CYC` cycles after the last refresh. Its `sd_addr` carries `cfg_burst_len` in bits 2:0, `cfg_burst_seq` in bit 3, `cfg_cas_lat` in bits 6:4, and zero in all other bits.
- R7: `init_done` rises exactly `T_RSC_CYC` cycles after the mode register set. It stays 1 until reset, and the pins read no-operation with a zero address while it is 1.
- R8: Every command lasts one cycle. Every cycle that is not one of the commands above shows no-operation with a zero `sd_addr`.
- R9: Asserting reset part-way through the sequence restarts it from index 0, with the same timing as a sequence that starts fresh from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_burst_seq | input | 1 | Burst ordering bit for the mode word |
| cfg_cas_lat | input | 3 | CAS latency code for the mode word |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_dqm | output | 1 | Data mask to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins: A10 option flag or mode word |
| init_done | output | 1 | High once the memory may accept traffic |

## Verification
The bench compares the pins on every cycle against an index-based model. Off-by-one errors in any gap therefore show up as a command that lands one cycle early or late. A refresh loop that stops one short or runs one long moves the mode set or adds a stray refresh, and the per-cycle check catches both. The mode-word check uses random configuration values, so swapped or shifted fields produce a wrong address on the mode-set cycle. Some runs are cut short by reset at a random index. This exposes a refresh counter or gap timer that keeps stale state and shortens or reorders the next sequence.

// File: rtl/sdram_init_pkg.sv
// Package: shared command encoding, sequence states and mode-word layout for
// the SDRAM power-up sequencer. Assumes active-low command pins in the
// order {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_STABLE,
        ST_PRECH,
        ST_TRP,
        ST_REF,
        ST_TRC,
        ST_MRS,
        ST_TRSC,
        ST_READY
    } init_state_e;

    // Mode word field positions, decoded by the memory itself.
    localparam int MR_BL_LSB   = 0;
    localparam int MR_BT_BIT   = 3;
    localparam int MR_CL_LSB   = 4;
    localparam int PRE_ALL_BIT = 10;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/init_gap_timer.sv
// Gap timer: counts cycles spent in the current sequence state.
// Assumes the owner pulses clr on every state change. hit is high when the
// count has reached limit. The count saturates there.
module init_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;

    // Compare the running count with the limit chosen for this state.
    assign hit = (cnt_q == limit);

    // Clear on a state change, otherwise advance until the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (!hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/init_ref_counter.sv
// Refresh counter: counts the auto-refresh commands issued in this sequence.
// Assumes issue is high for exactly one cycle per refresh. all_done is high
// once REF_COUNT refreshes have gone out.
module init_ref_counter #(
    parameter int REF_COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic issue,
    output logic all_done
);
    localparam int RC_W = $clog2(REF_COUNT + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(REF_COUNT);

    logic [RC_W-1:0] cnt_q;

    // Flag the end of the refresh burst.
    assign all_done = (cnt_q == RC_LAST);

    // Count refreshes, restart when the sequence restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (issue && !all_done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/init_cmd_drive.sv
// Command driver: turns a sequence command into pin levels and the address
// word. Assumes ADDR_W is at least 11, so the precharge-all flag bit
// exists. Purely combinational.
module init_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  sd_cmd_e           cmd,
    input  logic [2:0]        burst_len,
    input  logic              burst_seq,
    input  logic [2:0]        cas_lat,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] mode_word;

    // Place the mode fields at the positions the memory decodes.
    always_comb begin
        mode_word = '0;
        mode_word[MR_BL_LSB +: 3] = burst_len;
        mode_word[MR_BT_BIT]      = burst_seq;
        mode_word[MR_CL_LSB +: 3] = cas_lat;
    end

    // Map the command code onto the four strobes.
    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    // Choose the address content by command.
    always_comb begin
        addr = '0;
        case (cmd)
            CMD_PRE: addr[PRE_ALL_BIT] = 1'b1;
            CMD_MRS: addr = mode_word;
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/sdram_pwrup_seq.sv
// SDRAM power-up sequencer top. Runs a quiet period, then precharge-all,
// then REFRESH_COUNT auto-refreshes, then a mode register set, then raises
// init_done. Every wait is a parameter. Assumes all gaps are at least two
// cycles, WAIT_STABLE_CYC is at least one, and cfg inputs are stable.
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W          = 12,
    parameter int WAIT_STABLE_CYC = 50000,
    parameter int T_RP_CYC        = 3,
    parameter int T_RC_CYC        = 7,
    parameter int T_RSC_CYC       = 2,
    parameter int REFRESH_COUNT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_seq,
    input  logic [2:0]        cfg_cas_lat,
    output logic              sd_cke,
    output logic              sd_dqm,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);
    localparam int MAX_GAP = max_of4(WAIT_STABLE_CYC, T_RP_CYC, T_RC_CYC, T_RSC_CYC);
    localparam int CNT_W   = $clog2(MAX_GAP + 1);
    localparam logic [CNT_W-1:0] LIM_STABLE = CNT_W'(WAIT_STABLE_CYC - 1);
    localparam logic [CNT_W-1:0] LIM_TRP    = CNT_W'(T_RP_CYC - 2);
    localparam logic [CNT_W-1:0] LIM_TRC    = CNT_W'(T_RC_CYC - 2);
    localparam logic [CNT_W-1:0] LIM_TRSC   = CNT_W'(T_RSC_CYC - 2);

    // Elaboration checks on the parameters.
    if (REFRESH_COUNT < 8) begin : g_bad_refresh_count
        initial $fatal(1, "REFRESH_COUNT must be at least 8");
    end
    if (T_RP_CYC < 2 || T_RC_CYC < 2 || T_RSC_CYC < 2) begin : g_bad_gap
        initial $fatal(1, "command gaps must be at least 2 cycles");
    end
    if (WAIT_STABLE_CYC < 1 || ADDR_W < 11) begin : g_bad_setup
        initial $fatal(1, "WAIT_STABLE_CYC >= 1 and ADDR_W >= 11 required");
    end

    init_state_e       state_q, state_d;
    logic [CNT_W-1:0]  gap_limit;
    logic              gap_hit;
    logic              refs_done;
    sd_cmd_e           cur_cmd;

    // Pick the terminal count for the state being timed.
    always_comb begin
        case (state_q)
            ST_STABLE: gap_limit = LIM_STABLE;
            ST_TRP:    gap_limit = LIM_TRP;
            ST_TRC:    gap_limit = LIM_TRC;
            ST_TRSC:   gap_limit = LIM_TRSC;
            default:   gap_limit = '0;
        endcase
    end

    init_gap_timer #(
        .CNT_W (CNT_W)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .limit (gap_limit),
        .hit   (gap_hit)
    );

    init_ref_counter #(
        .REF_COUNT (REFRESH_COUNT)
    ) u_refs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == ST_STABLE),
        .issue    (state_q == ST_REF),
        .all_done (refs_done)
    );

    // Next-state logic for the fixed initialization order.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_STABLE: if (gap_hit) state_d = ST_PRECH;
            ST_PRECH:  state_d = ST_TRP;
            ST_TRP:    if (gap_hit) state_d = ST_REF;
            ST_REF:    state_d = ST_TRC;
            ST_TRC:    if (gap_hit) state_d = refs_done ? ST_MRS : ST_REF;
            ST_MRS:    state_d = ST_TRSC;
            ST_TRSC:   if (gap_hit) state_d = ST_READY;
            ST_READY:  state_d = ST_READY;
            default:   state_d = ST_STABLE;
        endcase
    end

    // State register, restarting from the quiet period on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Decode the one-cycle command owned by the current state.
    always_comb begin
        case (state_q)
            ST_PRECH: cur_cmd = CMD_PRE;
            ST_REF:   cur_cmd = CMD_REF;
            ST_MRS:   cur_cmd = CMD_MRS;
            default:  cur_cmd = CMD_NOP;
        endcase
    end

    init_cmd_drive #(
        .ADDR_W (ADDR_W)
    ) u_drive (
        .cmd       (cur_cmd),
        .burst_len (cfg_burst_len),
        .burst_seq (cfg_burst_seq),
        .cas_lat   (cfg_cas_lat),
        .cs_n      (sd_cs_n),
        .ras_n     (sd_ras_n),
        .cas_n     (sd_cas_n),
        .we_n      (sd_we_n),
        .addr      (sd_addr)
    );

    assign sd_cke    = 1'b1;
    assign sd_dqm    = 1'b1;
    assign init_done = (state_q == ST_READY);
endmodule

// File: rtl/init_seq_checker.sv
// Checker for the power-up sequencer: observes the pins only and tracks
// command spacing and the refresh tally in its own counters.
module init_seq_checker
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int T_RC_CYC      = 7,
    parameter int REFRESH_COUNT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cke,
    input logic              sd_dqm,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);
    logic [3:0]  cmd;
    logic [15:0] since_cmd;
    logic [15:0] refs_seen;
    logic        last_was_ref;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // Track cycles since the last command and how many refreshes went out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cmd    <= '0;
            refs_seen    <= '0;
            last_was_ref <= 1'b0;
        end else if (cmd != CMD_NOP) begin
            since_cmd    <= 16'd1;
            last_was_ref <= (cmd == CMD_REF);
            if (cmd == CMD_REF && refs_seen != 16'hFFFF) refs_seen <= refs_seen + 1'b1;
        end else if (since_cmd != 16'hFFFF) begin
            since_cmd <= since_cmd + 1'b1;
        end
    end

    p_pins_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke && sd_dqm);

    p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (sd_addr == (ADDR_W'(1) << PRE_ALL_BIT)));

    p_ref_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF && last_was_ref) |-> (since_cmd >= 16'(T_RC_CYC)));

    p_mrs_after_refs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> (refs_seen >= 16'(REFRESH_COUNT)));

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == CMD_NOP && sd_addr == '0));

    p_one_cycle_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));
endmodule

bind sdram_pwrup_seq init_seq_checker #(
    .ADDR_W        (ADDR_W),
    .T_RC_CYC      (T_RC_CYC),
    .REFRESH_COUNT (REFRESH_COUNT)
) u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cke    (sd_cke),
    .sd_dqm    (sd_dqm),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .init_done (init_done)
);

// File: tb/sdram_pwrup_seq_tb_top.sv
// Bench: several runs with random mode fields, some cut short by reset,
// every cycle compared against an index-based model of the sequence.
module sdram_pwrup_seq_tb_top;
    localparam int AW   = 12;
    localparam int W    = 20;
    localparam int TRP  = 3;
    localparam int TRC  = 7;
    localparam int TRSC = 2;
    localparam int NREF = 8;
    localparam int PRE_IDX  = W;
    localparam int REF0_IDX = W + TRP;
    localparam int MRS_IDX  = REF0_IDX + NREF * TRC;
    localparam int DONE_IDX = MRS_IDX + TRSC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bl = 3'd0;
    logic          bt = 1'b0;
    logic [2:0]    cl = 3'd0;
    logic          cke, dqm, cs_n, ras_n, cas_n, we_n, done;
    logic [AW-1:0] addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sdram_pwrup_seq #(
        .ADDR_W (AW), .WAIT_STABLE_CYC (W), .T_RP_CYC (TRP),
        .T_RC_CYC (TRC), .T_RSC_CYC (TRSC), .REFRESH_COUNT (NREF)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_burst_len (bl), .cfg_burst_seq (bt), .cfg_cas_lat (cl),
        .sd_cke (cke), .sd_dqm (dqm),
        .sd_cs_n (cs_n), .sd_ras_n (ras_n), .sd_cas_n (cas_n), .sd_we_n (we_n),
        .sd_addr (addr), .init_done (done)
    );

    function automatic logic [3:0] exp_cmd(input int idx);
        if (idx == PRE_IDX) return 4'b0010;
        if (idx == MRS_IDX) return 4'b0000;
        for (int k = 0; k < NREF; k++)
            if (idx == REF0_IDX + k * TRC) return 4'b0001;
        return 4'b0111;
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int idx, input logic [2:0] b,
                                               input logic s, input logic [2:0] c);
        logic [3:0] e;
        e = exp_cmd(idx);
        if (e == 4'b0010) return AW'(1) << 10;
        if (e == 4'b0000) return AW'({c, s, b});
        return '0;
    endfunction

    function automatic string tag_of(input logic [3:0] e);
        case (e)
            4'b0010: return "R2 R3";
            4'b0001: return "R4 R5";
            4'b0000: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input int idx, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s idx=%0d actual=%h expected=%h", req, idx, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        bit restarted;
        void'($urandom(32'd4711));
        restarted = 1'b0;
        for (int run = 0; run < 8; run++) begin
            int stop_at;
            string r9;
            bl = 3'($urandom);
            bt = 1'($urandom);
            cl = 3'($urandom);
            if (run == 2) begin bl = 3'b111; bt = 1'b1; cl = 3'b111; end
            if (run == 3) begin bl = 3'b000; bt = 1'b0; cl = 3'b000; end
            stop_at = (run % 2 == 1) ? 1 + int'($urandom % (DONE_IDX + 1)) : DONE_IDX + 10;
            if (run == 5) stop_at = REF0_IDX + 3 * TRC;
            r9 = restarted ? " R9" : "";
            // Reset phase: R1
            @(negedge clk);
            rst_n = 1'b0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check({"R1", r9}, -1, {26'd0, cke, dqm, cs_n, ras_n, cas_n, we_n},
                      {26'd0, 6'b110111});
                check("R1", -1, 32'(addr), 32'd0);
                check("R1", -1, 32'(done), 32'd0);
            end
            rst_n = 1'b1;
            for (int idx = 0; idx <= stop_at; idx++) begin
                logic [3:0] e;
                if (idx > 0) @(negedge clk);
                e = exp_cmd(idx);
                check({tag_of(e), r9}, idx, 32'({cs_n, ras_n, cas_n, we_n}), 32'(e));
                check({tag_of(e), r9}, idx, 32'(addr), 32'(exp_addr(idx, bl, bt, cl)));
                check({"R7", r9}, idx, 32'(done), 32'(idx >= DONE_IDX));
                check("R1", idx, 32'({cke, dqm}), 32'd3);
            end
            restarted = (stop_at < DONE_IDX);
        end
        finish_run();
    end
endmodule